// File: doc/BRIEF.md
# Basic-Block Reuse Lookup Comparator

This block decides, at the entry of a basic block, whether the work of the whole block can be skipped. It holds a small direct-mapped table of recorded blocks. A lookup is started with the start address of the fetched block. When the stored tag equals that address, the block waits for the operands to become ready. It then compares every recorded register input against the live register file through its read ports. After that it checks every recorded memory input, one at a time, through a single data-cache probe port. A cache miss on a probe counts as a mismatch.

When every recorded input matches, the block signals a skip. In imprecise-exception mode it also supplies the stored successor address so that the next PC can be redirected. In precise-exception mode it instead raises a mark-completed signal, and the instructions still issue but take no execution resources. On a tag miss or any input mismatch it reports the outcome, and the pipeline executes the block normally. Normal execution continues while a comparison is in progress. A recorder fills entries from committed instructions, and each fill replaces the entry at its index outright.

Top module: `blk_reuse_cmp`

## Requirements
- R1: After reset no outcome is reported, every outcome output is zero, and every table entry is empty, so any lookup reports a miss.
- R2: A lookup in idle whose address differs from the tag at index `pc[IDX_W+1:2]`, or hits an empty entry, gives `done` one cycle after the lookup with `outcome` = 3'b100 (bit 2 = miss).
- R3: On a tag hit no outcome is given until `ops_ready` is sampled high. In that cycle each valid register slot is compared with `rf_rdata` for its index. Any difference gives `outcome` = 3'b010 (bit 1 = mismatch) one cycle later.
- R4: Register and memory slots whose valid bit is clear have no effect on the outcome. Register slot i uses bits `[i*RIDX_W +: RIDX_W]` of the index vectors and `[i*DATA_W +: DATA_W]` of the value vectors. Memory slot i uses the same `[i*W +: W]` layout.
- R5: After the register check passes, valid memory slots are probed one at a time in ascending slot order. `probe_req` stays high and `probe_addr` stays steady until `probe_ack`. Invalid slots are never probed.
- R6: A probe answered with `probe_hit` low, or with `probe_data` that differs from the stored value, ends the check with the mismatch outcome. No further slot is probed.
- R7: When every valid input matches, `outcome` = 3'b001 (bit 0 = skip). With `precise_mode` low, `redirect_vld` is high and `redirect_pc` carries the stored successor address in the same cycle.
- R8: With `precise_mode` high, a skip raises `mark_cmpl` and leaves `redirect_vld` low and `redirect_pc` zero.
- R9: A fill writes the whole entry at its index and replaces any older one. A lookup in the same cycle as a fill to the same index sees the contents from before the fill.
- R10: A lookup presented while a comparison is in progress is ignored and produces no outcome of its own.
- R11: `done` is a single-cycle pulse. `outcome` is one-hot while `done` is high, and `outcome`, `redirect_vld`, `redirect_pc` and `mark_cmpl` are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Start a lookup for a fetched block |
| lk_pc | input | ADDR_W | Start address of the fetched block |
| precise_mode | input | 1 | 1: skip by marking completed, 0: skip by redirect |
| ops_ready | input | 1 | Block operands are ready (issue time) |
| rf_raddr | output | NREG*RIDX_W | Register file read indices, one per register slot |
| rf_rdata | input | NREG*DATA_W | Live register values for the read indices |
| probe_req | output | 1 | Data-cache probe request |
| probe_addr | output | ADDR_W | Address being probed |
| probe_ack | input | 1 | Probe answered this cycle |
| probe_hit | input | 1 | Probe found the line in the cache |
| probe_data | input | DATA_W | Cached value returned by the probe |
| fill_valid | input | 1 | Write a recorded entry |
| fill_pc | input | ADDR_W | Block start address (tag and index) |
| fill_next_pc | input | ADDR_W | Successor block address |
| fill_reg_vld | input | NREG | Register slot valid bits |
| fill_reg_idx | input | NREG*RIDX_W | Register slot indices |
| fill_reg_val | input | NREG*DATA_W | Recorded register values |
| fill_mem_vld | input | NMEM | Memory slot valid bits |
| fill_mem_addr | input | NMEM*ADDR_W | Recorded memory addresses |
| fill_mem_val | input | NMEM*DATA_W | Recorded memory values |
| done | output | 1 | Outcome pulse |
| outcome | output | 3 | One-hot: bit 0 skip, bit 1 mismatch, bit 2 miss |
| redirect_vld | output | 1 | Redirect next PC (imprecise skip) |
| redirect_pc | output | ADDR_W | Stored successor address |
| mark_cmpl | output | 1 | Mark block instructions completed (precise skip) |

## Verification
A corrupted table entry or snapshot shows up at the ports on the next lookup of that index. The symptom is a wrong outcome class, a wrong `redirect_pc`, or a register read or probe at the wrong index or address, and it appears within the cycles of that one comparison. A wrong sequencer state shows within a cycle or two. It appears as a probe to a skipped slot, a probe after a failed one, a missing or doubled `done`, or an outcome that arrives before `ops_ready`. The reference model in the bench tracks every probe address and output on every clock, so any of these is caught in the cycle it occurs.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PROBE = 2'd2
    } brc_state_e;

    localparam logic [2:0] OUTC_SKIP     = 3'b001;
    localparam logic [2:0] OUTC_MISMATCH = 3'b010;
    localparam logic [2:0] OUTC_MISS     = 3'b100;

endpackage

// File: rtl/brc_table.sv
module brc_table #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int NREG   = 2,
    parameter int RIDX_W = 5,
    parameter int NMEM   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_valid,
    input  logic [IDX_W-1:0]         fill_idx,
    input  logic [ADDR_W-1:0]        fill_pc,
    input  logic [ADDR_W-1:0]        fill_next_pc,
    input  logic [NREG-1:0]          fill_reg_vld,
    input  logic [NREG*RIDX_W-1:0]   fill_reg_idx,
    input  logic [NREG*DATA_W-1:0]   fill_reg_val,
    input  logic [NMEM-1:0]          fill_mem_vld,
    input  logic [NMEM*ADDR_W-1:0]   fill_mem_addr,
    input  logic [NMEM*DATA_W-1:0]   fill_mem_val,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic                     rd_vld,
    output logic [ADDR_W-1:0]        rd_tag,
    output logic [ADDR_W-1:0]        rd_next,
    output logic [NREG-1:0]          rd_reg_vld,
    output logic [NREG*RIDX_W-1:0]   rd_reg_idx,
    output logic [NREG*DATA_W-1:0]   rd_reg_val,
    output logic [NMEM-1:0]          rd_mem_vld,
    output logic [NMEM*ADDR_W-1:0]   rd_mem_addr,
    output logic [NMEM*DATA_W-1:0]   rd_mem_val
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic                   vld;
        logic [ADDR_W-1:0]      tag;
        logic [ADDR_W-1:0]      nxt;
        logic [NREG-1:0]        rvld;
        logic [NREG*RIDX_W-1:0] ridx;
        logic [NREG*DATA_W-1:0] rval;
        logic [NMEM-1:0]        mvld;
        logic [NMEM*ADDR_W-1:0] maddr;
        logic [NMEM*DATA_W-1:0] mval;
    } ent_t;

    ent_t tab_q [DEPTH];
    ent_t tab_d [DEPTH];

    // Next-state: a fill overwrites the whole entry at its index.
    always_comb begin
        tab_d = tab_q;
        if (fill_valid) begin
            tab_d[fill_idx].vld   = 1'b1;
            tab_d[fill_idx].tag   = fill_pc;
            tab_d[fill_idx].nxt   = fill_next_pc;
            tab_d[fill_idx].rvld  = fill_reg_vld;
            tab_d[fill_idx].ridx  = fill_reg_idx;
            tab_d[fill_idx].rval  = fill_reg_val;
            tab_d[fill_idx].mvld  = fill_mem_vld;
            tab_d[fill_idx].maddr = fill_mem_addr;
            tab_d[fill_idx].mval  = fill_mem_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    // Read port shows registered contents (pre-fill in a fill cycle).
    assign rd_vld      = tab_q[rd_idx].vld;
    assign rd_tag      = tab_q[rd_idx].tag;
    assign rd_next     = tab_q[rd_idx].nxt;
    assign rd_reg_vld  = tab_q[rd_idx].rvld;
    assign rd_reg_idx  = tab_q[rd_idx].ridx;
    assign rd_reg_val  = tab_q[rd_idx].rval;
    assign rd_mem_vld  = tab_q[rd_idx].mvld;
    assign rd_mem_addr = tab_q[rd_idx].maddr;
    assign rd_mem_val  = tab_q[rd_idx].mval;

    // R9: a fill leaves a valid entry tagged with the filled address
    p_fill_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (tab_q[$past(fill_idx)].vld && tab_q[$past(fill_idx)].tag == $past(fill_pc)));

endmodule

// File: rtl/brc_reg_match.sv
module brc_reg_match #(
    parameter int NREG   = 2,
    parameter int DATA_W = 32
) (
    input  logic [NREG-1:0]        slot_vld,
    input  logic [NREG*DATA_W-1:0] slot_val,
    input  logic [NREG*DATA_W-1:0] live_val,
    output logic                   all_ok
);

    logic [NREG-1:0] slot_ok;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slot_ok[g] = !slot_vld[g] ||
                            (slot_val[g*DATA_W +: DATA_W] == live_val[g*DATA_W +: DATA_W]);
    end

    assign all_ok = &slot_ok;

endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 2,
    parameter int RIDX_W = 5,
    parameter int NMEM   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_pc,
    input  logic                     precise_mode,
    input  logic                     ops_ready,
    input  logic                     tb_vld,
    input  logic [ADDR_W-1:0]        tb_tag,
    input  logic [ADDR_W-1:0]        tb_next,
    input  logic [NREG-1:0]          tb_reg_vld,
    input  logic [NREG*RIDX_W-1:0]   tb_reg_idx,
    input  logic [NREG*DATA_W-1:0]   tb_reg_val,
    input  logic [NMEM-1:0]          tb_mem_vld,
    input  logic [NMEM*ADDR_W-1:0]   tb_mem_addr,
    input  logic [NMEM*DATA_W-1:0]   tb_mem_val,
    input  logic                     reg_ok,
    input  logic                     probe_ack,
    input  logic                     probe_hit,
    input  logic [DATA_W-1:0]        probe_data,
    output logic [NREG-1:0]          snap_reg_vld,
    output logic [NREG*RIDX_W-1:0]   snap_reg_idx,
    output logic [NREG*DATA_W-1:0]   snap_reg_val,
    output logic                     probe_req,
    output logic [ADDR_W-1:0]        probe_addr,
    output logic                     done,
    output logic [2:0]               outcome,
    output logic                     redirect_vld,
    output logic [ADDR_W-1:0]        redirect_pc,
    output logic                     mark_cmpl
);

    localparam int SLOT_W = (NMEM > 1) ? $clog2(NMEM) : 1;

    typedef struct packed {
        brc_state_e             st;
        logic [ADDR_W-1:0]      nxt;
        logic [NREG-1:0]        rvld;
        logic [NREG*RIDX_W-1:0] ridx;
        logic [NREG*DATA_W-1:0] rval;
        logic [NMEM-1:0]        mvld;
        logic [NMEM*ADDR_W-1:0] maddr;
        logic [NMEM*DATA_W-1:0] mval;
        logic [SLOT_W-1:0]      slot;
        logic                   done;
        logic [2:0]             outc;
        logic                   redir;
        logic [ADDR_W-1:0]      tgt;
        logic                   mark;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [SLOT_W:0] nx_slot;
    logic            fin_skip, fin_mis, fin_miss;
    logic            tag_hit;
    logic            mem_ok;

    // Lowest valid memory slot at or above 'start'; MSB flags found.
    function automatic logic [SLOT_W:0] first_from(input logic [NMEM-1:0] v, input int start);
        logic [SLOT_W:0] r;
        r = '0;
        for (int i = NMEM - 1; i >= 0; i--) begin
            if (i >= start && v[i]) begin
                r = {1'b1, i[SLOT_W-1:0]};
            end
        end
        return r;
    endfunction

    assign tag_hit = tb_vld && (tb_tag == lk_pc);
    assign mem_ok  = probe_hit && (probe_data == s_q.mval[s_q.slot*DATA_W +: DATA_W]);

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.outc  = '0;
        s_d.redir = 1'b0;
        s_d.tgt   = '0;
        s_d.mark  = 1'b0;
        nx_slot   = '0;
        fin_skip  = 1'b0;
        fin_mis   = 1'b0;
        fin_miss  = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (lk_valid) begin
                    if (tag_hit) begin
                        s_d.st    = ST_WAIT;
                        s_d.nxt   = tb_next;
                        s_d.rvld  = tb_reg_vld;
                        s_d.ridx  = tb_reg_idx;
                        s_d.rval  = tb_reg_val;
                        s_d.mvld  = tb_mem_vld;
                        s_d.maddr = tb_mem_addr;
                        s_d.mval  = tb_mem_val;
                        s_d.slot  = '0;
                    end else begin
                        fin_miss = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (ops_ready) begin
                    if (!reg_ok) begin
                        fin_mis = 1'b1;
                    end else begin
                        nx_slot = first_from(s_q.mvld, 0);
                        if (nx_slot[SLOT_W]) begin
                            s_d.st   = ST_PROBE;
                            s_d.slot = nx_slot[SLOT_W-1:0];
                        end else begin
                            fin_skip = 1'b1;
                        end
                    end
                end
            end
            ST_PROBE: begin
                if (probe_ack) begin
                    if (!mem_ok) begin
                        fin_mis = 1'b1;
                    end else begin
                        nx_slot = first_from(s_q.mvld, int'(s_q.slot) + 1);
                        if (nx_slot[SLOT_W]) begin
                            s_d.slot = nx_slot[SLOT_W-1:0];
                        end else begin
                            fin_skip = 1'b1;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (fin_skip || fin_mis || fin_miss) begin
            s_d.st   = ST_IDLE;
            s_d.done = 1'b1;
        end
        if (fin_skip) begin
            s_d.outc = OUTC_SKIP;
            if (precise_mode) begin
                s_d.mark = 1'b1;
            end else begin
                s_d.redir = 1'b1;
                s_d.tgt   = s_q.nxt;
            end
        end
        if (fin_mis) begin
            s_d.outc = OUTC_MISMATCH;
        end
        if (fin_miss) begin
            s_d.outc = OUTC_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap_reg_vld = s_q.rvld;
    assign snap_reg_idx = s_q.ridx;
    assign snap_reg_val = s_q.rval;
    assign probe_req    = (s_q.st == ST_PROBE);
    assign probe_addr   = s_q.maddr[s_q.slot*ADDR_W +: ADDR_W];
    assign done         = s_q.done;
    assign outcome      = s_q.outc;
    assign redirect_vld = s_q.redir;
    assign redirect_pc  = s_q.tgt;
    assign mark_cmpl    = s_q.mark;

    // R3: no outcome while operands are not ready
    p_wait_for_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT && !ops_ready) |=> !done);

    // R5: an outstanding probe keeps its request and address
    p_probe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !probe_ack) |=> (probe_req && $stable(probe_addr)));

    // R6: a probe miss ends the walk with a mismatch
    p_miss_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_ack && !probe_hit) |=> (!probe_req && done && outcome == OUTC_MISMATCH));

    // R7 / R8: a skip takes exactly one of the two routes
    p_skip_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome[0]) |-> (redirect_vld != mark_cmpl));

    // R11: one-hot outcome on done, quiet otherwise, single-cycle pulse
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(outcome) == 1));
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (outcome == 3'b000 && !redirect_vld && !mark_cmpl && redirect_pc == '0));
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/blk_reuse_cmp.sv
module blk_reuse_cmp #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int NREG   = 2,
    parameter int RIDX_W = 5,
    parameter int NMEM   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_pc,
    input  logic                     precise_mode,
    input  logic                     ops_ready,
    output logic [NREG*RIDX_W-1:0]   rf_raddr,
    input  logic [NREG*DATA_W-1:0]   rf_rdata,
    output logic                     probe_req,
    output logic [ADDR_W-1:0]        probe_addr,
    input  logic                     probe_ack,
    input  logic                     probe_hit,
    input  logic [DATA_W-1:0]        probe_data,
    input  logic                     fill_valid,
    input  logic [ADDR_W-1:0]        fill_pc,
    input  logic [ADDR_W-1:0]        fill_next_pc,
    input  logic [NREG-1:0]          fill_reg_vld,
    input  logic [NREG*RIDX_W-1:0]   fill_reg_idx,
    input  logic [NREG*DATA_W-1:0]   fill_reg_val,
    input  logic [NMEM-1:0]          fill_mem_vld,
    input  logic [NMEM*ADDR_W-1:0]   fill_mem_addr,
    input  logic [NMEM*DATA_W-1:0]   fill_mem_val,
    output logic                     done,
    output logic [2:0]               outcome,
    output logic                     redirect_vld,
    output logic [ADDR_W-1:0]        redirect_pc,
    output logic                     mark_cmpl
);

    localparam int PC_OFF = 2;

    logic                   tb_vld;
    logic [ADDR_W-1:0]      tb_tag, tb_next;
    logic [NREG-1:0]        tb_reg_vld, snap_reg_vld;
    logic [NREG*RIDX_W-1:0] tb_reg_idx, snap_reg_idx;
    logic [NREG*DATA_W-1:0] tb_reg_val, snap_reg_val;
    logic [NMEM-1:0]        tb_mem_vld;
    logic [NMEM*ADDR_W-1:0] tb_mem_addr;
    logic [NMEM*DATA_W-1:0] tb_mem_val;
    logic                   reg_ok;

    brc_table #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .NREG(NREG), .RIDX_W(RIDX_W), .NMEM(NMEM)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_idx     (fill_pc[PC_OFF +: IDX_W]),
        .fill_pc      (fill_pc),
        .fill_next_pc (fill_next_pc),
        .fill_reg_vld (fill_reg_vld),
        .fill_reg_idx (fill_reg_idx),
        .fill_reg_val (fill_reg_val),
        .fill_mem_vld (fill_mem_vld),
        .fill_mem_addr(fill_mem_addr),
        .fill_mem_val (fill_mem_val),
        .rd_idx       (lk_pc[PC_OFF +: IDX_W]),
        .rd_vld       (tb_vld),
        .rd_tag       (tb_tag),
        .rd_next      (tb_next),
        .rd_reg_vld   (tb_reg_vld),
        .rd_reg_idx   (tb_reg_idx),
        .rd_reg_val   (tb_reg_val),
        .rd_mem_vld   (tb_mem_vld),
        .rd_mem_addr  (tb_mem_addr),
        .rd_mem_val   (tb_mem_val)
    );

    brc_reg_match #(
        .NREG(NREG), .DATA_W(DATA_W)
    ) u_reg_match (
        .slot_vld(snap_reg_vld),
        .slot_val(snap_reg_val),
        .live_val(rf_rdata),
        .all_ok  (reg_ok)
    );

    brc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
        .RIDX_W(RIDX_W), .NMEM(NMEM)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_pc        (lk_pc),
        .precise_mode (precise_mode),
        .ops_ready    (ops_ready),
        .tb_vld       (tb_vld),
        .tb_tag       (tb_tag),
        .tb_next      (tb_next),
        .tb_reg_vld   (tb_reg_vld),
        .tb_reg_idx   (tb_reg_idx),
        .tb_reg_val   (tb_reg_val),
        .tb_mem_vld   (tb_mem_vld),
        .tb_mem_addr  (tb_mem_addr),
        .tb_mem_val   (tb_mem_val),
        .reg_ok       (reg_ok),
        .probe_ack    (probe_ack),
        .probe_hit    (probe_hit),
        .probe_data   (probe_data),
        .snap_reg_vld (snap_reg_vld),
        .snap_reg_idx (snap_reg_idx),
        .snap_reg_val (snap_reg_val),
        .probe_req    (probe_req),
        .probe_addr   (probe_addr),
        .done         (done),
        .outcome      (outcome),
        .redirect_vld (redirect_vld),
        .redirect_pc  (redirect_pc),
        .mark_cmpl    (mark_cmpl)
    );

    assign rf_raddr = snap_reg_idx;

endmodule

// File: tb/blk_reuse_cmp_tb_top.sv
module blk_reuse_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        precise_mode = 1'b0;
    logic        ops_ready = 1'b0;
    logic [9:0]  rf_raddr;
    logic [63:0] rf_rdata;
    logic        probe_req;
    logic [31:0] probe_addr;
    logic        probe_ack = 1'b0;
    logic        probe_hit = 1'b0;
    logic [31:0] probe_data = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_pc = '0, fill_next_pc = '0;
    logic [1:0]  fill_reg_vld = '0;
    logic [9:0]  fill_reg_idx = '0;
    logic [63:0] fill_reg_val = '0;
    logic [1:0]  fill_mem_vld = '0;
    logic [63:0] fill_mem_addr = '0;
    logic [63:0] fill_mem_val = '0;
    logic        done;
    logic [2:0]  outcome;
    logic        redirect_vld;
    logic [31:0] redirect_pc;
    logic        mark_cmpl;

    always #5 clk = ~clk;

    blk_reuse_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .precise_mode(precise_mode), .ops_ready(ops_ready),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .probe_req(probe_req), .probe_addr(probe_addr), .probe_ack(probe_ack),
        .probe_hit(probe_hit), .probe_data(probe_data),
        .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_next_pc(fill_next_pc),
        .fill_reg_vld(fill_reg_vld), .fill_reg_idx(fill_reg_idx), .fill_reg_val(fill_reg_val),
        .fill_mem_vld(fill_mem_vld), .fill_mem_addr(fill_mem_addr), .fill_mem_val(fill_mem_val),
        .done(done), .outcome(outcome), .redirect_vld(redirect_vld),
        .redirect_pc(redirect_pc), .mark_cmpl(mark_cmpl)
    );

    // Bench register file and data cache
    logic [31:0] rf_mem [32];
    logic [31:0] cache [int unsigned];
    assign rf_rdata[31:0]  = rf_mem[rf_raddr[4:0]];
    assign rf_rdata[63:32] = rf_mem[rf_raddr[9:5]];

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          t_vld [8];
    logic [31:0] t_tag [8], t_nxt [8];
    logic [1:0]  t_rvld [8], t_mvld [8];
    logic [4:0]  t_ridx [8][2];
    logic [31:0] t_rval [8][2], t_maddr [8][2], t_mval [8][2];
    int          m_st = 0;   // 0 idle, 1 waiting for operands, 2 probing
    int          m_slot = 0;
    logic [31:0] s_nxt;
    logic [1:0]  s_rvld, s_mvld;
    logic [4:0]  s_ridx [2];
    logic [31:0] s_rval [2], s_maddr [2], s_mval [2];
    bit          e_done = 0, e_redir = 0, e_mark = 0;
    logic [2:0]  e_out = '0;
    logic [31:0] e_tgt = '0;

    function automatic int next_mem(input int from);
        for (int s = from; s < 2; s++) if (s_mvld[s]) return s;
        return -1;
    endfunction

    always @(posedge clk) begin
        int ix;
        int fin;
        bit bad;
        if (!rst_n) begin
            m_st = 0; e_done = 0; e_out = '0; e_redir = 0; e_tgt = '0; e_mark = 0;
            for (int i = 0; i < 8; i++) t_vld[i] = 0;
        end else begin
            fin = 0;
            e_done = 0; e_out = '0; e_redir = 0; e_tgt = '0; e_mark = 0;
            case (m_st)
                0: if (lk_valid) begin
                    ix = int'((lk_pc >> 2) & 32'd7);
                    if (t_vld[ix] && t_tag[ix] == lk_pc) begin
                        s_nxt = t_nxt[ix]; s_rvld = t_rvld[ix]; s_mvld = t_mvld[ix];
                        for (int s = 0; s < 2; s++) begin
                            s_ridx[s] = t_ridx[ix][s]; s_rval[s] = t_rval[ix][s];
                            s_maddr[s] = t_maddr[ix][s]; s_mval[s] = t_mval[ix][s];
                        end
                        m_st = 1;
                    end else fin = 3;
                end
                1: if (ops_ready) begin
                    bad = 0;
                    for (int s = 0; s < 2; s++)
                        if (s_rvld[s] && rf_mem[s_ridx[s]] != s_rval[s]) bad = 1;
                    if (bad) fin = 2;
                    else begin
                        m_slot = next_mem(0);
                        if (m_slot < 0) fin = 1; else m_st = 2;
                    end
                end
                default: if (probe_ack) begin
                    if (!probe_hit || probe_data != s_mval[m_slot]) fin = 2;
                    else begin
                        m_slot = next_mem(m_slot + 1);
                        if (m_slot < 0) fin = 1;
                    end
                end
            endcase
            if (fill_valid) begin
                ix = int'((fill_pc >> 2) & 32'd7);
                t_vld[ix] = 1; t_tag[ix] = fill_pc; t_nxt[ix] = fill_next_pc;
                t_rvld[ix] = fill_reg_vld; t_mvld[ix] = fill_mem_vld;
                for (int s = 0; s < 2; s++) begin
                    t_ridx[ix][s]  = fill_reg_idx[s*5 +: 5];
                    t_rval[ix][s]  = fill_reg_val[s*32 +: 32];
                    t_maddr[ix][s] = fill_mem_addr[s*32 +: 32];
                    t_mval[ix][s]  = fill_mem_val[s*32 +: 32];
                end
            end
            if (fin != 0) begin
                m_st = 0; e_done = 1;
                if (fin == 1) begin
                    e_out = 3'b001;
                    if (precise_mode) e_mark = 1; else begin e_redir = 1; e_tgt = s_nxt; end
                end else if (fin == 2) e_out = 3'b010;
                else e_out = 3'b100;
            end
        end
    end

    // ---------------- per-cycle comparison and done log ----------------
    int          done_cnt = 0;
    logic [2:0]  last_out = '0;
    logic [31:0] last_tgt = '0;
    bit          last_redir = 0, last_mark = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(done == e_done, cur_req, "done", 64'(done), 64'(e_done));
            check(outcome == e_out, cur_req, "outcome", 64'(outcome), 64'(e_out));
            check(redirect_vld == e_redir && mark_cmpl == e_mark && redirect_pc == e_tgt,
                  cur_req, "redirect/mark", {31'd0, redirect_vld, mark_cmpl, redirect_pc},
                  {31'd0, e_redir, e_mark, e_tgt});
            check(probe_req == (m_st == 2), "R5", "probe_req", 64'(probe_req), 64'(m_st == 2));
            if (m_st == 2)
                check(probe_addr == s_maddr[m_slot], "R5", "probe_addr", 64'(probe_addr),
                      64'(s_maddr[m_slot]));
            if (done) begin
                done_cnt++;
                last_out = outcome; last_tgt = redirect_pc;
                last_redir = redirect_vld; last_mark = mark_cmpl;
            end
        end
    end

    // ---------------- cache probe responder ----------------
    int          resp_lat = 0;
    int          lat_cnt = 0;
    logic [31:0] plog [$];

    always @(negedge clk) begin
        if (probe_ack) begin
            probe_ack = 1'b0; probe_hit = 1'b0; lat_cnt = 0;
        end else if (probe_req && rst_n) begin
            if (lat_cnt >= resp_lat) begin
                probe_ack  = 1'b1;
                probe_hit  = cache.exists(probe_addr);
                probe_data = probe_hit ? cache[probe_addr] : 32'hdead_beef;
                plog.push_back(probe_addr);
            end else lat_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic fill_entry(input logic [31:0] pc, input logic [31:0] nxt,
                              input logic [1:0] rv, input logic [4:0] ri0, input logic [31:0] rx0,
                              input logic [4:0] ri1, input logic [31:0] rx1,
                              input logic [1:0] mv, input logic [31:0] ma0, input logic [31:0] md0,
                              input logic [31:0] ma1, input logic [31:0] md1);
        @(negedge clk);
        fill_valid = 1'b1; fill_pc = pc; fill_next_pc = nxt;
        fill_reg_vld = rv; fill_reg_idx = {ri1, ri0}; fill_reg_val = {rx1, rx0};
        fill_mem_vld = mv; fill_mem_addr = {ma1, ma0}; fill_mem_val = {md1, md0};
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic run_lookup(input logic [31:0] pc, input int ops_delay);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc;
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (ops_delay) @(negedge clk);
        ops_ready = 1'b1;
        @(negedge clk);
        ops_ready = 1'b0;
    endtask

    task automatic expect_one(input int n0, input logic [2:0] exp_out, input bit exp_redir,
                              input logic [31:0] exp_tgt, input bit exp_mark, input string req);
        #1;
        for (int i = 0; i < 40 && done_cnt <= n0; i++) begin
            @(negedge clk); #1;
        end
        repeat (3) @(negedge clk);
        #1;
        check(done_cnt == n0 + 1, req, "done pulses", 64'(done_cnt - n0), 64'd1);
        check(last_out == exp_out, req, "outcome", 64'(last_out), 64'(exp_out));
        check(last_redir == exp_redir && last_mark == exp_mark && last_tgt == exp_tgt, req,
              "route", {31'd0, last_redir, last_mark, last_tgt}, {31'd0, exp_redir, exp_mark, exp_tgt});
    endtask

    task automatic expect_plog(input logic [31:0] a0, input logic [31:0] a1, input int n, input string req);
        check(plog.size() == n, req, "probe count", 64'(plog.size()), 64'(n));
        if (plog.size() >= 1 && n >= 1) check(plog[0] == a0, req, "first probe", 64'(plog[0]), 64'(a0));
        if (plog.size() >= 2 && n >= 2) check(plog[1] == a1, req, "second probe", 64'(plog[1]), 64'(a1));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        int n0;
        for (int i = 0; i < 32; i++) rf_mem[i] = 32'h100 + i;
        rf_mem[3] = 32'h11; rf_mem[4] = 32'h44; rf_mem[5] = 32'h55; rf_mem[7] = 32'h12;
        cache[32'h1000] = 32'hAAAA; cache[32'h1004] = 32'hBBBB; cache[32'h2004] = 32'hCCCC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: quiet outputs after reset
        check(!done && outcome == 0 && !redirect_vld && !mark_cmpl && !probe_req, "R1",
              "reset outputs", {done, outcome, redirect_vld, mark_cmpl, probe_req}, 64'd0);

        // R1: empty table -> miss
        cur_req = "R1"; n0 = done_cnt;
        run_lookup(32'h100, 0);
        expect_one(n0, 3'b100, 0, 0, 0, "R1");

        fill_entry(32'h100, 32'h200, 2'b01, 5'd3, 32'h11, 5'd7, 32'h99, 2'b00, 0, 0, 0, 0);
        fill_entry(32'h104, 32'h300, 2'b11, 5'd4, 32'h44, 5'd5, 32'h55,
                   2'b11, 32'h1000, 32'hAAAA, 32'h1004, 32'hBBBB);
        fill_entry(32'h108, 32'h400, 2'b00, 5'd0, 0, 5'd0, 0,
                   2'b10, 32'h2000, 32'h7777, 32'h2004, 32'hCCCC);

        // R3 R4 R7: register match after delayed operands, invalid slot 1 ignored
        cur_req = "R7"; n0 = done_cnt;
        run_lookup(32'h100, 3);
        expect_one(n0, 3'b001, 1, 32'h200, 0, "R7");

        // R2: same index, different tag
        cur_req = "R2"; n0 = done_cnt;
        run_lookup(32'h120, 0);
        expect_one(n0, 3'b100, 0, 0, 0, "R2");

        // R3: register value differs
        cur_req = "R3"; rf_mem[3] = 32'h13; n0 = done_cnt;
        run_lookup(32'h100, 1);
        expect_one(n0, 3'b010, 0, 0, 0, "R3");
        rf_mem[3] = 32'h11;

        // R5 R8: two memory slots in order, precise mode marks completed
        cur_req = "R8"; precise_mode = 1'b1; resp_lat = 2; plog.delete(); n0 = done_cnt;
        run_lookup(32'h104, 0);
        expect_one(n0, 3'b001, 0, 0, 1, "R8");
        expect_plog(32'h1000, 32'h1004, 2, "R5");
        precise_mode = 1'b0;

        // R6: second probe misses in the cache
        cur_req = "R6"; cache.delete(32'h1004); plog.delete(); n0 = done_cnt;
        run_lookup(32'h104, 0);
        expect_one(n0, 3'b010, 0, 0, 0, "R6");
        expect_plog(32'h1000, 32'h1004, 2, "R6");
        cache[32'h1004] = 32'hBBBB;

        // R6: first probe returns a different value, second slot never probed
        cache[32'h1000] = 32'hABAB; plog.delete(); resp_lat = 0; n0 = done_cnt;
        run_lookup(32'h104, 0);
        expect_one(n0, 3'b010, 0, 0, 0, "R6");
        expect_plog(32'h1000, 0, 1, "R6");
        cache[32'h1000] = 32'hAAAA;

        // R4 R5: invalid memory slot 0 skipped, only slot 1 probed
        cur_req = "R4"; plog.delete(); resp_lat = 1; n0 = done_cnt;
        run_lookup(32'h108, 0);
        expect_one(n0, 3'b001, 1, 32'h400, 0, "R4");
        expect_plog(32'h2004, 0, 1, "R5");

        // R10: lookup while waiting for operands is ignored
        cur_req = "R10"; n0 = done_cnt;
        @(negedge clk); lk_valid = 1'b1; lk_pc = 32'h100;
        @(negedge clk); lk_pc = 32'h120;
        @(negedge clk); lk_valid = 1'b0;
        @(negedge clk); ops_ready = 1'b1;
        @(negedge clk); ops_ready = 1'b0;
        expect_one(n0, 3'b001, 1, 32'h200, 0, "R10");

        // R9: fill and lookup to the same index in one cycle -> old entry used
        cur_req = "R9"; n0 = done_cnt;
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'h100;
        fill_valid = 1'b1; fill_pc = 32'h120; fill_next_pc = 32'h500;
        fill_reg_vld = 2'b00; fill_mem_vld = 2'b00;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; ops_ready = 1'b1;
        @(negedge clk); ops_ready = 1'b0;
        expect_one(n0, 3'b001, 1, 32'h200, 0, "R9");

        // R9: old tag now replaced
        n0 = done_cnt;
        run_lookup(32'h100, 0);
        expect_one(n0, 3'b100, 0, 0, 0, "R9");
        n0 = done_cnt;
        run_lookup(32'h120, 0);
        expect_one(n0, 3'b001, 1, 32'h500, 0, "R9");

        // R11: outcome pulses were single-cycle (checked per cycle); final quiet state
        cur_req = "R11";
        repeat (2) @(negedge clk);
        #1;
        check(!done && outcome == 0, "R11", "idle after outcome", {done, outcome}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule